// File: doc/BRIEF.md
# Keyed Watchdog and Reset Controller

This block is a small memory-mapped peripheral that lets software force a system reset through a watchdog countdown. It holds three 32-bit registers. A control register carries a two-bit reset-type field. A status register holds flags that boot code reads after a reset. A count register holds the watchdog load value and reads back the ticks that remain. Every write must carry the key byte 0x5A in bits [31:24]. A write with any other key byte changes nothing.

Software first loads the count register. It then writes a non-zero reset type into the control field with a read-modify-write. The countdown then runs on a slow tick, which comes from a prescaler on the system clock. When the count runs out, the block raises a reset request for a fixed number of clocks and reports the reset type beside it. At the end of the pulse it clears the control field, which disarms the watchdog. The status flags, for example the hard-reset indication in bit 6, are cleared only by the power-on reset input or by a keyed software write. The watchdog's own reset request never clears them.

Top module: `wdog_rstctl`

## Requirements
- R1: After `rst` all three registers read 0, `sys_rst_req` is low and `rst_kind` is 2'b00. `rst` is synchronous and active high, and it is the power-on reset.
- R2: A write whose bits [31:24] are not 0x5A is ignored entirely. No register changes and the watchdog does not arm.
- R3: Offset 0x1C is the control register, 0x20 the status register and 0x24 the count register. Control and status store bits [23:0] of a keyed write. Every read returns zeros in bits [31:24]. A read of any other offset returns 0. Read data appears one clock after `rd_en`.
- R4: A keyed write to the count register loads bits [19:0] as the tick count, so 0xFFFFF is the largest load. A read returns the remaining ticks in bits [19:0] and zeros above them.
- R5: The reset-type field is control bits [5:4]. The countdown runs only while the field is non-zero. Writing 2'b00 stops the count, and the remaining value holds until the field is armed again.
- R6: One tick occurs every TICK_DIV clocks. The prescaler restarts on arming and on every count load. With a load of N ≥ 1, the request rises exactly N·TICK_DIV clocks after the edge that arms the watchdog.
- R7: On expiry `sys_rst_req` is high for exactly PULSE_LEN (16) clocks. For that whole time `rst_kind` shows the field value in force at expiry: 2'b10 is a full reset, and 2'b01 and 2'b11 also expire with their own code.
- R8: When the pulse ends the reset-type field becomes 2'b00. The other control bits keep their value, the count reads 0 and no further request follows.
- R9: The status flags, including the hard-reset flag in bit 6, are unchanged by the watchdog request. Only `rst` or a keyed status write changes them.
- R10: A count of 0 that is armed expires on the first tick, TICK_DIV clocks after arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data, key byte in bits [31:24] |
| rdata | output | 32 | Registered read data |
| sys_rst_req | output | 1 | Reset request pulse to the reset consumers |
| rst_kind | output | 2 | Reset type shown during the request |

## Verification
Several properties are checked on every cycle. A wrongly keyed write leaves the status flags alone. The request pulse never lasts more or fewer than PULSE_LEN clocks, and it always carries a non-zero reset type. The count only holds or steps down by one between loads, and it holds while the field is zero. The field is clear when the pulse ends. The status register is stable throughout a request. Only the bench scenarios can show the absolute timing: expiry after exactly N·TICK_DIV clocks, the resume after a disarm, and the zero-load case. They also show that register read-back, the key rejection seen through reads, and the survival of the flags across a full watchdog reset hold end to end.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  localparam int DATA_W   = 32;
  localparam int KEY_W    = 8;
  localparam int REG_W    = DATA_W - KEY_W;
  localparam logic [KEY_W-1:0] WR_KEY = 8'h5A;

  localparam int OFF_CTRL = 8'h1C;
  localparam int OFF_STAT = 8'h20;
  localparam int OFF_CNT  = 8'h24;

  localparam int CFG_LSB  = 4;
  localparam int CFG_MSB  = 5;

  typedef enum logic {
    WD_IDLE  = 1'b0,
    WD_PULSE = 1'b1
  } wd_state_e;
endpackage

// File: rtl/wdr_prescaler.sv
module wdr_prescaler #(
  parameter int TICK_DIV = 750
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pcnt_q;

  assign tick = (pcnt_q == LAST) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt_q <= '0;
    end else if (pcnt_q == LAST) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdr_countdown.sv
module wdr_countdown
  import wdr_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [1:0]       cfg,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             req_q,
  output logic [1:0]       kind_q,
  output logic             armed,
  output logic             done
);
  localparam int LW = $clog2(PULSE_LEN + 1);
  localparam logic [LW-1:0] LEN_LAST = LW'(PULSE_LEN - 1);

  wd_state_e      state_q;
  logic [LW-1:0]  plen_q;
  logic           expire;

  assign armed  = (cfg != 2'b00) && (state_q == WD_IDLE);
  assign expire = armed && tick && !load_en && (cnt_q <= CNT_W'(1));
  assign done   = (state_q == WD_PULSE) && (plen_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_en) begin
      cnt_q <= load_val;
    end else if (expire) begin
      cnt_q <= '0;
    end else if (armed && tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WD_IDLE;
      plen_q  <= '0;
      req_q   <= 1'b0;
      kind_q  <= 2'b00;
    end else begin
      case (state_q)
        WD_IDLE: begin
          if (expire) begin
            state_q <= WD_PULSE;
            plen_q  <= LEN_LAST;
            req_q   <= 1'b1;
            kind_q  <= cfg;
          end
        end
        WD_PULSE: begin
          if (plen_q == '0) begin
            state_q <= WD_IDLE;
            req_q   <= 1'b0;
            kind_q  <= 2'b00;
          end else begin
            plen_q <= plen_q - 1'b1;
          end
        end
        default: state_q <= WD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdr_regs.sv
module wdr_regs
  import wdr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_cfg,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [1:0]        cfg,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  stat_q,
  output logic              cnt_ld,
  output logic [CNT_W-1:0]  cnt_ld_val,
  output logic [DATA_W-1:0] rdata
);
  logic key_ok;
  logic sel_ctrl, sel_stat, sel_cnt;

  assign key_ok   = (wdata[DATA_W-1:REG_W] == WR_KEY);
  assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
  assign sel_stat = (addr == ADDR_W'(OFF_STAT));
  assign sel_cnt  = (addr == ADDR_W'(OFF_CNT));

  assign cnt_ld     = wr_en && key_ok && sel_cnt;
  assign cnt_ld_val = wdata[CNT_W-1:0];
  assign cfg        = ctrl_q[CFG_MSB:CFG_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_en && key_ok && sel_ctrl) begin
        ctrl_q <= wdata[REG_W-1:0];
      end
      if (clr_cfg) begin
        ctrl_q[CFG_MSB:CFG_LSB] <= 2'b00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (wr_en && key_ok && sel_stat) begin
      stat_q <= wdata[REG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (sel_ctrl) begin
        rdata <= DATA_W'(ctrl_q);
      end else if (sel_stat) begin
        rdata <= DATA_W'(stat_q);
      end else if (sel_cnt) begin
        rdata <= DATA_W'(cnt_val);
      end else begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/wdog_rstctl.sv
module wdog_rstctl
  import wdr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 20,
  parameter int TICK_DIV  = 750,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              sys_rst_req,
  output logic [1:0]        rst_kind
);
  logic [1:0]       cfg_q;
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] stat_q;
  logic             cnt_ld;
  logic [CNT_W-1:0] cnt_ld_val;
  logic [CNT_W-1:0] cnt_q;
  logic             armed;
  logic             done;
  logic             tick;

  wdr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .clr_cfg(done), .cnt_val(cnt_q), .cfg(cfg_q),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .cnt_ld(cnt_ld),
    .cnt_ld_val(cnt_ld_val), .rdata(rdata)
  );

  wdr_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst(rst), .restart(!armed || cnt_ld), .tick(tick)
  );

  wdr_countdown #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_cnt (
    .clk(clk), .rst(rst), .load_en(cnt_ld), .load_val(cnt_ld_val),
    .cfg(cfg_q), .tick(tick), .cnt_q(cnt_q), .req_q(sys_rst_req),
    .kind_q(rst_kind), .armed(armed), .done(done)
  );
endmodule

// File: rtl/wdog_rstctl_chk.sv
module wdog_rstctl_chk
  import wdr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 20,
  parameter int PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              sys_rst_req,
  input logic [1:0]        rst_kind,
  input logic [1:0]        cfg_q,
  input logic [REG_W-1:0]  stat_q,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam int RW = $clog2(PULSE_LEN + 1) + 1;

  logic [RW-1:0] run_q;
  logic          keyed, ld_cnt, ld_stat;

  assign keyed   = wr_en && (wdata[31:24] == WR_KEY);
  assign ld_cnt  = keyed && (addr == ADDR_W'(OFF_CNT));
  assign ld_stat = keyed && (addr == ADDR_W'(OFF_STAT));

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (sys_rst_req) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  p_badkey_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[31:24] != WR_KEY) |=> $stable(stat_q));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q == 2'b00 && !ld_cnt) |=> $stable(cnt_q));

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    !ld_cnt |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1));

  p_kind_r7: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> rst_kind != 2'b00);

  p_pulse_max_r7: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> run_q < RW'(PULSE_LEN));

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_req) |-> $past(run_q) == RW'(PULSE_LEN - 1));

  p_cfg_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_req) |-> cfg_q == 2'b00);

  p_stat_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_req && !ld_stat) |=> $stable(stat_q));
endmodule

bind wdog_rstctl wdog_rstctl_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .sys_rst_req(sys_rst_req), .rst_kind(rst_kind), .cfg_q(cfg_q),
  .stat_q(stat_q), .cnt_q(cnt_q)
);

// File: tb/wdog_rstctl_test.sv
`timescale 1ns/1ps
module wdog_rstctl_test;
  localparam int DIV  = 4;
  localparam int PLEN = 16;
  localparam int NVEC = 8;
  // {addr, wdata, expected read-back}
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h1C, 32'h5A00_0F0F, 32'h0000_0F0F},   // R3 control store
    {8'h20, 32'h5A12_3440, 32'h0012_3440},   // R3 status store
    {8'h24, 32'h5AFF_FFFF, 32'h000F_FFFF},   // R4 max load, upper zero
    {8'h24, 32'h5A00_0007, 32'h0000_0007},   // R4 plain load
    {8'h1C, 32'h3300_00FF, 32'h0000_0F0F},   // R2 bad key on control
    {8'h20, 32'hA500_0000, 32'h0012_3440},   // R2 bad key on status
    {8'h40, 32'h5A00_1234, 32'h0000_0000},   // R3 unmapped offset
    {8'h20, 32'h5A00_0000, 32'h0000_0000}    // R9 keyed clear
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_rst_req;
  logic [1:0]  rst_kind;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wdog_rstctl #(.TICK_DIV(DIV), .PULSE_LEN(PLEN)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req),
    .rst_kind(rst_kind)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // returns cycles from the arming edge to the request, then the width
  task automatic measure(input logic [1:0] exp_kind, input string req,
                         output int dly, output int wid);
    dly = 0;
    while (!sys_rst_req && dly < 100000) begin
      @(negedge clk);
      dly++;
    end
    wid = 0;
    while (sys_rst_req && wid < 1000) begin
      check(req, {30'b0, rst_kind}, {30'b0, exp_kind});
      @(negedge clk);
      wid++;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v, v1, v2;
    int dly, wid;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 req", {31'b0, sys_rst_req}, 32'h0);
    check("R1 kind", {30'b0, rst_kind}, 32'h0);
    rd(8'h1C, v); check("R1 ctrl", v, 32'h0);
    rd(8'h20, v); check("R1 stat", v, 32'h0);
    rd(8'h24, v); check("R1 count", v, 32'h0);

    // table walk: write then read back
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      check("R2/R3/R4/R9 table", v, VEC[i][31:0]);
    end
    check("R2 no arm", {31'b0, sys_rst_req}, 32'h0);

    // R6/R7/R8/R9 full reset with hard flag set
    wr(8'h20, 32'h5A00_0040);
    wr(8'h24, 32'h5A00_000A);
    rd(8'h1C, v);
    wr(8'h1C, (v & 32'hFFFF_FFCF) | 32'h5A00_0020);
    measure(2'b10, "R7 kind full", dly, wid);
    check("R6 expiry delay", dly, 10 * DIV);
    check("R7 pulse width", wid, PLEN);
    rd(8'h1C, v); check("R8 field cleared", v, 32'h0000_0F0F);
    rd(8'h24, v); check("R8 count zero", v, 32'h0);
    repeat (50) @(negedge clk);
    check("R8 no refire", {31'b0, sys_rst_req}, 32'h0);
    rd(8'h20, v); check("R9 flag survives", v, 32'h0000_0040);

    // R5 disarm holds the remaining count
    wr(8'h24, 32'h5A00_0014);
    wr(8'h1C, 32'h5A00_0F1F);
    repeat (3 * DIV + 2) @(negedge clk);
    wr(8'h1C, 32'h5A00_0F0F);
    rd(8'h24, v1);
    repeat (40) @(negedge clk);
    rd(8'h24, v2);
    check("R5 count held", v2, v1);
    check("R5 count moved", {31'b0, (v1 < 32'd20 && v1 > 32'd0)}, 32'h1);
    check("R5 no request", {31'b0, sys_rst_req}, 32'h0);
    wr(8'h1C, 32'h5A00_0F3F);
    measure(2'b11, "R7 kind 11", dly, wid);
    check("R6 resume delay", dly, v1 * DIV);
    check("R7 width 11", wid, PLEN);

    // R10 zero load expires on first tick
    wr(8'h24, 32'h5A00_0000);
    wr(8'h1C, 32'h5A00_0F2F);
    measure(2'b10, "R10 kind", dly, wid);
    check("R10 first tick", dly, DIV);

    // R1/R9 power-on reset clears the flags
    wr(8'h20, 32'h5A00_0040);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(8'h20, v); check("R9 cleared by rst", v, 32'h0);

    finish_run();
  end
endmodule